// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block turns activity on a bank of synchronized GPIO inputs into up to sixteen interrupt flags. The inputs are grouped into ports of sixteen pins each. Interrupt line n always watches pin n, and a per-line 3-bit selector chooses which port supplies that pin. Each line can be armed for rising edges, falling edges, both or neither. A detected edge latches a flag bit whether or not the line is enabled.

Software controls the block through a small register window on a simple write-strobe bus, with a combinational read port. Flags can be set by software as well as by hardware. A driver can therefore re-raise a flag when a pin is still at its active level, which gives level-style behaviour on top of the edge detector. Flags are cleared by writing ones to a clear register.

Two request outputs leave the block. One covers the even-numbered lines and one covers the odd-numbered lines, each gated by a per-line enable. Pad synchronization, pin muxing and the downstream interrupt controller belong elsewhere.

Top module: `gpio_ext_irq`

## Requirements
- R1: Line n (0..15) samples `pin_in[16*p + n]`, where p is its 3-bit selector. Selectors for lines 0..7 sit at byte address 0x100 and those for lines 8..15 at 0x104, in bits [4*(n mod 8)+2 : 4*(n mod 8)]. A selector value at or above the number of ports selects a constant low input.
- R2: When bit n of the rising-enable register (0x108) is set, flag n is set at the first clock edge at which line n's input is 1 after being 0 at the previous edge. A falling transition does not set it.
- R3: When bit n of the falling-enable register (0x10C) is set, flag n is set at the first clock edge at which line n's input is 0 after being 1 at the previous edge. A rising transition does not set it.
- R4: The flags read back at 0x114 (bit n = line n). A detected edge sets its flag even when the line's enable bit at 0x110 is clear.
- R5: Writing to 0x118 sets every flag whose data bit is 1 and leaves the other flags unchanged.
- R6: Writing to 0x11C clears every flag whose data bit is 1. If a hardware edge targets the same bit in the same cycle, the flag ends up set.
- R7: `irq_even` is high exactly when some even-numbered line has both its flag and its enable (0x110) set. `irq_odd` is the same for odd-numbered lines.
- R8: Writing a new selector value causes no edge on that line, even when the old and new inputs differ.
- R9: 0x120 is a plain 32-bit read/write register. 0x118 and 0x11C read as zero. The unused top bit of every selector nibble reads as zero.
- R10: After reset every register and flag reads zero and both request outputs are low.
- R11: A transition on a line with both edge enables clear sets no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PORTS*16 | Synchronized GPIO inputs, port p pin k at bit 16*p+k |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_even | output | 1 | Request for even-numbered lines |
| irq_odd | output | 1 | Request for odd-numbered lines |

## Verification
The edge path is tried with a table of patterns. Each pattern varies the selected port, the port that actually toggles, the line (low and high selector register), the edge direction and the armed enables. Matching port and direction must flag, while a toggle on a non-selected port or in an unarmed direction must not. This separates port decode from pin decode from edge polarity. Out-of-range selectors, a live reselection between ports at different levels, and a clear colliding with an edge on the same bit are driven directly. Software set and enable gating are then used to split the two request outputs by line parity.

// File: rtl/gpio_eic_pkg.sv
package gpio_eic_pkg;

    localparam int LINES  = 16;
    localparam int SEL_W  = 3;
    localparam int DW     = 32;
    localparam int AW     = 9;
    localparam int NIB    = 4;
    localparam int HALF   = LINES / 2;

    localparam logic [AW-1:0] A_SRC_LO = 9'h100;
    localparam logic [AW-1:0] A_SRC_HI = 9'h104;
    localparam logic [AW-1:0] A_RISE   = 9'h108;
    localparam logic [AW-1:0] A_FALL   = 9'h10C;
    localparam logic [AW-1:0] A_ENA    = 9'h110;
    localparam logic [AW-1:0] A_FLAG   = 9'h114;
    localparam logic [AW-1:0] A_SETF   = 9'h118;
    localparam logic [AW-1:0] A_CLRF   = 9'h11C;
    localparam logic [AW-1:0] A_SPARE  = 9'h120;

    typedef enum logic [3:0] {
        RG_NONE, RG_SRC_LO, RG_SRC_HI, RG_RISE, RG_FALL,
        RG_ENA, RG_FLAG, RG_SETF, RG_CLRF, RG_SPARE
    } reg_id_e;

    typedef struct packed {
        logic [LINES-1:0][SEL_W-1:0] src;
        logic [LINES-1:0]            rise;
        logic [LINES-1:0]            fall;
        logic [LINES-1:0]            ena;
    } eic_cfg_t;

    function automatic reg_id_e reg_decode(input logic [AW-1:0] a);
        case (a)
            A_SRC_LO: return RG_SRC_LO;
            A_SRC_HI: return RG_SRC_HI;
            A_RISE:   return RG_RISE;
            A_FALL:   return RG_FALL;
            A_ENA:    return RG_ENA;
            A_FLAG:   return RG_FLAG;
            A_SETF:   return RG_SETF;
            A_CLRF:   return RG_CLRF;
            A_SPARE:  return RG_SPARE;
            default:  return RG_NONE;
        endcase
    endfunction

    function automatic logic [LINES-1:0] parity_mask(input logic odd);
        logic [LINES-1:0] m;
        for (int i = 0; i < LINES; i++) m[i] = ((i % 2) == 1) == odd;
        return m;
    endfunction

endpackage

// File: rtl/gpio_eic_regs.sv
module gpio_eic_regs
    import gpio_eic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic [LINES-1:0] flag,
    output eic_cfg_t         cfg,
    output logic [LINES-1:0] sw_set,
    output logic [LINES-1:0] sw_clr,
    output logic [DW-1:0]    rdata
);

    eic_cfg_t    cfg_q;
    logic [DW-1:0] spare_q;
    reg_id_e     wr_id;
    reg_id_e     rd_id;

    assign wr_id = reg_decode(addr);
    assign rd_id = reg_decode(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            spare_q <= '0;
        end else if (wr_en) begin
            case (wr_id)
                RG_SRC_LO: for (int i = 0; i < HALF; i++)
                               cfg_q.src[i] <= wdata[NIB*i +: SEL_W];
                RG_SRC_HI: for (int i = 0; i < HALF; i++)
                               cfg_q.src[HALF+i] <= wdata[NIB*i +: SEL_W];
                RG_RISE:   cfg_q.rise <= wdata[LINES-1:0];
                RG_FALL:   cfg_q.fall <= wdata[LINES-1:0];
                RG_ENA:    cfg_q.ena  <= wdata[LINES-1:0];
                RG_SPARE:  spare_q    <= wdata;
                default:   ;
            endcase
        end
    end

    assign cfg    = cfg_q;
    assign sw_set = (wr_en && wr_id == RG_SETF) ? wdata[LINES-1:0] : '0;
    assign sw_clr = (wr_en && wr_id == RG_CLRF) ? wdata[LINES-1:0] : '0;

    always_comb begin
        rdata = '0;
        case (rd_id)
            RG_SRC_LO: for (int i = 0; i < HALF; i++)
                           rdata[NIB*i +: SEL_W] = cfg_q.src[i];
            RG_SRC_HI: for (int i = 0; i < HALF; i++)
                           rdata[NIB*i +: SEL_W] = cfg_q.src[HALF+i];
            RG_RISE:   rdata[LINES-1:0] = cfg_q.rise;
            RG_FALL:   rdata[LINES-1:0] = cfg_q.fall;
            RG_ENA:    rdata[LINES-1:0] = cfg_q.ena;
            RG_FLAG:   rdata[LINES-1:0] = flag;
            RG_SPARE:  rdata = spare_q;
            default:   rdata = '0;
        endcase
    end

    AST_SPARE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_id == RG_SPARE) |=> $stable(spare_q)); // R9

endmodule

// File: rtl/gpio_eic_line.sv
module gpio_eic_line
    import gpio_eic_pkg::*;
#(
    parameter int NUM_PORTS = 6,
    parameter int PINS      = 16,
    parameter int LINE_IDX  = 0
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_PORTS*PINS-1:0] pins,
    input  logic [SEL_W-1:0]          src,
    input  logic                      rise_en,
    input  logic                      fall_en,
    output logic                      hit
);

    logic             cur;
    logic             hist_q;
    logic [SEL_W-1:0] src_q;

    always_comb begin
        cur = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++)
            if (src == SEL_W'(p)) cur = pins[p*PINS + LINE_IDX];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= 1'b0;
            src_q  <= '0;
        end else begin
            hist_q <= cur;
            src_q  <= src;
        end
    end

    assign hit = (src == src_q) &&
                 ((rise_en && cur && !hist_q) || (fall_en && !cur && hist_q));

    AST_RESELECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (src != $past(src)) |-> !hit); // R8

endmodule

// File: rtl/gpio_eic_flags.sv
module gpio_eic_flags
    import gpio_eic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] hw_set,
    input  logic [LINES-1:0] sw_set,
    input  logic [LINES-1:0] sw_clr,
    input  logic [LINES-1:0] ena,
    output logic [LINES-1:0] flag,
    output logic             irq_even,
    output logic             irq_odd
);

    localparam logic [LINES-1:0] EVEN_M = parity_mask(1'b0);
    localparam logic [LINES-1:0] ODD_M  = parity_mask(1'b1);

    logic [LINES-1:0] flag_q;

    always_ff @(posedge clk) begin
        if (rst) flag_q <= '0;
        else     flag_q <= (flag_q & ~sw_clr) | sw_set | hw_set;
    end

    assign flag     = flag_q;
    assign irq_even = |(flag_q & ena & EVEN_M);
    assign irq_odd  = |(flag_q & ena & ODD_M);

    AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        |hw_set |=> ((flag_q & $past(hw_set)) == $past(hw_set))); // R6

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        |sw_clr |=> ((flag_q & $past(sw_clr & ~hw_set & ~sw_set)) == '0)); // R6

    AST_NO_CAUSELESS_FLAG: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(hw_set | sw_set)) == '0)); // R5

endmodule

// File: rtl/gpio_ext_irq.sv
module gpio_ext_irq
    import gpio_eic_pkg::*;
#(
    parameter int NUM_PORTS = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_PORTS*LINES-1:0] pin_in,
    input  logic                       reg_wr_en,
    input  logic [AW-1:0]              reg_addr,
    input  logic [DW-1:0]              reg_wdata,
    output logic [DW-1:0]              reg_rdata,
    output logic                       irq_even,
    output logic                       irq_odd
);

    eic_cfg_t         cfg;
    logic [LINES-1:0] flag;
    logic [LINES-1:0] sw_set;
    logic [LINES-1:0] sw_clr;
    logic [LINES-1:0] hits;

    gpio_eic_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_wr_en),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .flag   (flag),
        .cfg    (cfg),
        .sw_set (sw_set),
        .sw_clr (sw_clr),
        .rdata  (reg_rdata)
    );

    for (genvar n = 0; n < LINES; n++) begin : g_line
        gpio_eic_line #(
            .NUM_PORTS (NUM_PORTS),
            .PINS      (LINES),
            .LINE_IDX  (n)
        ) u_line (
            .clk     (clk),
            .rst     (rst),
            .pins    (pin_in),
            .src     (cfg.src[n]),
            .rise_en (cfg.rise[n]),
            .fall_en (cfg.fall[n]),
            .hit     (hits[n])
        );
    end

    gpio_eic_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .hw_set   (hits),
        .sw_set   (sw_set),
        .sw_clr   (sw_clr),
        .ena      (cfg.ena),
        .flag     (flag),
        .irq_even (irq_even),
        .irq_odd  (irq_odd)
    );

    AST_EVEN_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        irq_even |-> ((cfg.ena & parity_mask(1'b0)) != '0)); // R7

    AST_ODD_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        irq_odd |-> ((cfg.ena & parity_mask(1'b1)) != '0)); // R7

endmodule

// File: tb/gpio_ext_irq_test.sv
`timescale 1ns/1ps
module gpio_ext_irq_test;

    localparam int NP = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP*16-1:0] pins = '0;
    logic          wen = 1'b0;
    logic [8:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq_e, irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    gpio_ext_irq #(.NUM_PORTS(NP)) uut (
        .clk(clk), .rst(rst), .pin_in(pins), .reg_wr_en(wen),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
        .irq_even(irq_e), .irq_odd(irq_o)
    );

    typedef struct packed {
        logic [2:0] sel;
        logic [2:0] tog;
        logic [3:0] line;
        logic       rise;
        logic       fall;
        logic       up;
        logic       expect_hit;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 3'd0, 4'd0,  1'b1, 1'b0, 1'b1, 1'b1},  // R2 rise armed
        '{3'd0, 3'd0, 4'd0,  1'b1, 1'b0, 1'b0, 1'b0},  // R2 fall ignored
        '{3'd2, 3'd2, 4'd5,  1'b0, 1'b1, 1'b0, 1'b1},  // R3 fall armed
        '{3'd2, 3'd2, 4'd5,  1'b0, 1'b1, 1'b1, 1'b0},  // R3 rise ignored
        '{3'd3, 3'd1, 4'd9,  1'b1, 1'b1, 1'b1, 1'b0},  // R1 other port
        '{3'd5, 3'd5, 4'd15, 1'b1, 1'b1, 1'b0, 1'b1},  // R1 top port, high reg
        '{3'd1, 3'd1, 4'd12, 1'b0, 1'b0, 1'b1, 1'b0},  // R11 unarmed
        '{3'd4, 3'd4, 4'd7,  1'b1, 1'b1, 1'b1, 1'b1},  // R1 both armed
        '{3'd6, 3'd0, 4'd3,  1'b1, 1'b1, 1'b1, 1'b0},  // R1 out of range
        '{3'd7, 3'd5, 4'd8,  1'b1, 1'b1, 1'b0, 1'b0}   // R1 out of range
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        wen = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wen = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        for (int a = 'h100; a <= 'h120; a += 4) begin
            rd(9'(a), v);
            check("R10 reg reset", v, 32'h0);
        end
        check("R10 irq_even reset", {31'h0, irq_e}, 32'h0);
        check("R10 irq_odd reset",  {31'h0, irq_o}, 32'h0);

        // table walk over the edge path
        for (int i = 0; i < NV; i++) begin
            vec_t t = VEC[i];
            logic [31:0] selw;
            int bitpos;
            bitpos = int'(t.tog) * 16 + int'(t.line);
            @(negedge clk);
            pins = '0;
            if (!t.up) pins[bitpos] = 1'b1;
            selw = 32'(t.sel) << (4 * (int'(t.line) % 8));
            wr((t.line < 8) ? 9'h100 : 9'h104, selw);
            wr(9'h108, t.rise ? (32'h1 << t.line) : 32'h0);
            wr(9'h10C, t.fall ? (32'h1 << t.line) : 32'h0);
            repeat (2) @(negedge clk);
            wr(9'h11C, 32'hFFFF);
            pins[bitpos] = t.up;
            @(negedge clk);
            rd(9'h114, v);
            check($sformatf("R1/R2/R3/R11 vec%0d flags", i), v,
                  t.expect_hit ? (32'h1 << t.line) : 32'h0);
            check($sformatf("R4 vec%0d irq gated", i), {30'h0, irq_o, irq_e}, 32'h0);
        end
        wr(9'h104, 32'h0);

        // R8: reselect between ports at different levels
        @(negedge clk);
        pins = '0;
        pins[1*16 + 3] = 1'b1;
        wr(9'h100, 32'h0);
        wr(9'h108, 32'h0008);
        wr(9'h10C, 32'h0008);
        repeat (2) @(negedge clk);
        wr(9'h11C, 32'hFFFF);
        wr(9'h100, 32'h0000_1000);
        repeat (3) @(negedge clk);
        rd(9'h114, v);
        check("R8 no edge on reselect", v, 32'h0);
        // edge after reselect still detected
        pins[1*16 + 3] = 1'b0;
        @(negedge clk);
        rd(9'h114, v);
        check("R8 later edge seen", v, 32'h0008);

        // R6: clear and edge on the same bit in one cycle
        wr(9'h11C, 32'hFFFF);
        @(negedge clk);
        wen = 1'b1; addr = 9'h11C; wdata = 32'h0008;
        pins[1*16 + 3] = 1'b1;
        @(negedge clk);
        wen = 1'b0;
        rd(9'h114, v);
        check("R6 edge beats clear", v, 32'h0008);
        wr(9'h11C, 32'h0008);
        rd(9'h114, v);
        check("R6 clear works", v, 32'h0);
        wr(9'h108, 32'h0);
        wr(9'h10C, 32'h0);

        // R5 software set, R7 parity gating
        wr(9'h118, 32'h0003);
        rd(9'h114, v);
        check("R5 set flags", v, 32'h0003);
        wr(9'h118, 32'h0);
        rd(9'h114, v);
        check("R5 zero write no change", v, 32'h0003);
        check("R7 no enable no irq", {30'h0, irq_o, irq_e}, 32'h0);
        wr(9'h110, 32'h0001);
        check("R7 even only", {30'h0, irq_o, irq_e}, 32'h1);
        wr(9'h110, 32'h0002);
        check("R7 odd only", {30'h0, irq_o, irq_e}, 32'h2);
        wr(9'h11C, 32'h0002);
        check("R7 odd cleared", {30'h0, irq_o, irq_e}, 32'h0);
        wr(9'h110, 32'h0);
        wr(9'h11C, 32'hFFFF);

        // R9 readbacks
        wr(9'h100, 32'hFFFF_FFFF);
        rd(9'h100, v);
        check("R9 selector nibble mask", v, 32'h7777_7777);
        wr(9'h120, 32'hDEAD_BEEF);
        rd(9'h120, v);
        check("R9 spare rw", v, 32'hDEAD_BEEF);
        rd(9'h118, v);
        check("R9 set reads zero", v, 32'h0);
        rd(9'h11C, v);
        check("R9 clear reads zero", v, 32'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule